// File: doc/BRIEF.md
# Virtually Tagged Write-Back Data Cache

This block is a direct-mapped data cache sitting between a processor load/store port and a word-wide memory port. Its 8 KB are organised as 256 lines of eight 32-bit words. Each line is tagged by virtual address and by the process that owns it, so translation is needed only on a miss. Byte, halfword and word accesses are supported. A store narrower than a word is merged into the cached word under a byte-lane mask, and the lane arithmetic follows a per-access endianness input.

On a miss, a dirty victim is written back first. The victim's virtual address is rebuilt from its tag and its line index, and it is translated with the process ID held in that tag. The requested line is then translated and refilled, one word per memory beat. Any access whose address has a top nibble of 0x2 bypasses the cache entirely and becomes a single untranslated memory beat. If a translation faults, the access ends at once with a fault indication.

Top module: `vtc_cache`

## Requirements
- R1: After reset every tag word reads as 0xFFFF0000, which is a clean line with process field 0 and address tag 0x7FFF8. A read of an address in region 0xFFFF0000–0xFFFF1FFF with process 0 therefore hits without any memory or translation traffic.
- R2: An access whose address bits [31:28] equal 0x2 makes exactly one memory beat. That beat carries the unmodified CPU address, no translation request is made, and no cache line is changed.
- R3: A read hit completes with no memory beat and no translation. It returns the cached word.
- R4: A miss on a clean line issues one translation of the requested address, with the current process ID and the access's write flag. It then makes eight read beats at consecutive word addresses starting at the translated line base (physical address with bits [4:0] cleared).
- R5: A miss on a dirty line first translates the victim address {tag[31:13], index, 5'b0}, using the stored process field tag[8:1] with the write flag set. It then writes the victim's eight words to consecutive addresses from that translated base, and only after that refills.
- R6: A stored process ID that differs from the requesting one turns an address-tag match into a miss. The one exception is a read whose address has bits [31:28] equal to 0x1, which still hits.
- R7: Every cached store sets the line's dirty bit (tag bit 0). A refill installs the tag {addr[31:13], process ID at bits [12:1], dirty=0} before the store's dirty bit is applied.
- R8: A store of size byte (cpu_size=0) or halfword (cpu_size=1) replicates the low data across the word and updates only the selected lanes. The lane is addr[1:0] in little-endian mode and addr[1:0] XOR 3 when big_endian=1; a halfword uses lanes {1,0} or {3,2} according to bit 1 of that lane.
- R9: A load of size byte or halfword returns the cached word shifted right by 8 times the lane, masked to 8 or 16 bits and zero-extended. A word load (cpu_size=2) returns the word unchanged.
- R10: A faulting translation ends the access with cpu_done and cpu_fault both high. No further memory beat follows, nothing is written into the cache, and an earlier completed write-back is kept.
- R11: cpu_busy stays high from the cycle after acceptance until cpu_done. A memory request holds its valid signal, address and direction stable until it is accepted by mem_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian | input | 1 | Byte-lane order for the access being accepted |
| cpu_req | input | 1 | Access request, held until cpu_done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | Virtual byte address |
| cpu_wdata | input | 32 | Store data, low-aligned |
| cpu_pid | input | 8 | Current process ID |
| cpu_busy | output | 1 | Access in progress |
| cpu_done | output | 1 | One-cycle completion strobe |
| cpu_fault | output | 1 | Access aborted by a translation fault, valid with cpu_done |
| cpu_rdata | output | 32 | Load result, valid with cpu_done |
| tr_req | output | 1 | Translation request |
| tr_write | output | 1 | Translation is for a write |
| tr_vaddr | output | 32 | Virtual address to translate |
| tr_pid | output | 8 | Process ID for the translation |
| tr_ack | input | 1 | Translation result valid |
| tr_fault | input | 1 | Translation failed |
| tr_paddr | input | 32 | Physical address result |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_be | output | 4 | Byte enables of the beat |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Beat write data |
| mem_ready | input | 1 | Beat accepted; read data valid |
| mem_rdata | input | 32 | Beat read data |

## Verification
The assertions assume that the translation port answers only while tr_req is high. They also assume that mem_rdata is valid in the same cycle as mem_ready, and that cpu_req with its fields stays stable until cpu_done. The bench's translation model acknowledges in the request cycle, and its memory model accepts on alternate cycles, so the hold-until-ready rule is exercised on most beats. The processor side drives each request at a falling edge and drops it at the falling edge where completion is seen. A fixed offset in the translation model separates physical from virtual addresses, and one region of the translation model faults.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } vtc_size_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_TR_WB,
      ST_WB,
      ST_TR_FILL,
      ST_FILL,
      ST_UNC
   } vtc_state_e;

endpackage

// File: rtl/vtc_lane.sv
module vtc_lane
   import vtc_pkg::*;
(
   input  logic       big_i,
   input  vtc_size_e  size_i,
   input  logic [1:0] addr_lo_i,
   input  logic [31:0] wdata_i,
   input  logic [31:0] word_i,
   output logic [31:0] rdata_o,
   output logic [31:0] wrep_o,
   output logic [3:0]  be_o
);
   logic [1:0] lane;

   assign lane = addr_lo_i ^ {2{big_i}};

   always_comb begin
      case (size_i)
         SZ_BYTE: begin
            rdata_o = (word_i >> {lane, 3'b000}) & 32'h0000_00ff;
            wrep_o  = {4{wdata_i[7:0]}};
            be_o    = 4'b0001 << lane;
         end
         SZ_HALF: begin
            rdata_o = (word_i >> {lane[1], 4'b0000}) & 32'h0000_ffff;
            wrep_o  = {2{wdata_i[15:0]}};
            be_o    = 4'b0011 << {lane[1], 1'b0};
         end
         default: begin
            rdata_o = word_i;
            wrep_o  = wdata_i;
            be_o    = 4'b1111;
         end
      endcase
   end
endmodule

// File: rtl/vtc_tag_store.sv
module vtc_tag_store #(
   parameter int          LINES     = 256,
   parameter int          IDX_W     = 8,
   parameter int          TAG_W     = 32,
   parameter logic [31:0] RESET_VAL = 32'hffff_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx_i,
   output logic [TAG_W-1:0] tag_o,
   input  logic             wr_en_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   input  logic             set_dirty_i
);
   logic [TAG_W-1:0] tags [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) tags[i] <= RESET_VAL[TAG_W-1:0];
      end else if (wr_en_i) begin
         tags[idx_i] <= wr_tag_i;
      end else if (set_dirty_i) begin
         tags[idx_i][0] <= 1'b1;
      end
   end

   assign tag_o = tags[idx_i];

   // R7: a store leaves the addressed line marked dirty
   a_r7_dirty_after_store: assert property (@(posedge clk) disable iff (!rst_n)
      set_dirty_i |=> tags[$past(idx_i)][0]);
endmodule

// File: rtl/vtc_data_store.sv
module vtc_data_store #(
   parameter int WORDS = 2048,
   parameter int AW    = 11,
   parameter int LANES = 4
) (
   input  logic               clk,
   input  logic [AW-1:0]      addr_i,
   output logic [8*LANES-1:0] rd_o,
   input  logic               wr_en_i,
   input  logic [LANES-1:0]   be_i,
   input  logic [8*LANES-1:0] wr_i
);
   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic [7:0] bank [WORDS];
      always_ff @(posedge clk) begin
         if (wr_en_i && be_i[b]) bank[addr_i] <= wr_i[8*b +: 8];
      end
      assign rd_o[8*b +: 8] = bank[addr_i];
   end
endmodule

// File: rtl/vtc_ctrl.sv
module vtc_ctrl
   import vtc_pkg::*;
#(
   parameter int         PID_W     = 8,
   parameter int         OFF_W     = 5,
   parameter int         IDX_W     = 8,
   parameter int         WOFF_W    = 3,
   parameter logic [3:0] UNC_NIB   = 4'h2,
   parameter logic [3:0] SHARE_NIB = 4'h1,
   localparam int        TAG_LO    = OFF_W + IDX_W,
   localparam int        PIDF_W    = TAG_LO - 1,
   localparam int        DAW       = IDX_W + WOFF_W,
   localparam int        LINE_W    = 1 << WOFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_endian,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_size,
   input  logic [31:0]       cpu_addr,
   input  logic [31:0]       cpu_wdata,
   input  logic [PID_W-1:0]  cpu_pid,
   output logic              cpu_busy,
   output logic              cpu_done,
   output logic              cpu_fault,
   output logic              tr_req,
   output logic              tr_write,
   output logic [31:0]       tr_vaddr,
   output logic [PID_W-1:0]  tr_pid,
   input  logic              tr_ack,
   input  logic              tr_fault,
   input  logic [31:0]       tr_paddr,
   output logic              mem_valid,
   output logic              mem_we,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ready,
   input  logic [31:0]       mem_rdata,
   output logic [IDX_W-1:0]  tag_idx,
   input  logic [31:0]       tag_rd,
   output logic              tag_wr_en,
   output logic [31:0]       tag_wr,
   output logic              tag_set_dirty,
   output logic [DAW-1:0]    dat_addr,
   input  logic [31:0]       dat_rd,
   output logic              dat_wr_en,
   output logic [3:0]        dat_be,
   output logic [31:0]       dat_wr,
   output logic              q_big,
   output vtc_size_e         q_size,
   output logic [1:0]        q_addr_lo,
   output logic [31:0]       q_wdata,
   output logic              q_we,
   output logic              sel_mem,
   input  logic [3:0]        lane_be,
   input  logic [31:0]       lane_wrep
);
   localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(LINE_W - 1);

   vtc_state_e          state, state_nx;
   logic [31:0]         q_addr;
   logic [PID_W-1:0]    q_pid;
   logic [WOFF_W-1:0]   beat;
   logic [31:0]         base;

   logic [31-TAG_LO:0]  tag_addr;
   logic [PIDF_W-1:0]   tag_pidf;
   logic                tag_dirty;
   logic                addr_match, pid_match, shared_rd, hit;
   logic                beat_go;

   assign tag_addr  = tag_rd[31:TAG_LO];
   assign tag_pidf  = tag_rd[PIDF_W:1];
   assign tag_dirty = tag_rd[0];
   assign q_addr_lo = q_addr[1:0];

   assign addr_match = (tag_addr == q_addr[31:TAG_LO]);
   assign pid_match  = (tag_pidf == PIDF_W'(q_pid));
   assign shared_rd  = !q_we && (q_addr[31:28] == SHARE_NIB);
   assign hit        = addr_match && (pid_match || shared_rd);
   assign beat_go    = mem_valid && mem_ready;

   // request capture, beat counter, line base
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         q_addr  <= '0;
         q_pid   <= '0;
         q_we    <= 1'b0;
         q_size  <= SZ_WORD;
         q_wdata <= '0;
         q_big   <= 1'b0;
         beat    <= '0;
         base    <= '0;
      end else begin
         state <= state_nx;
         if (state == ST_IDLE && cpu_req) begin
            q_addr  <= cpu_addr;
            q_pid   <= cpu_pid;
            q_we    <= cpu_we;
            q_size  <= vtc_size_e'(cpu_size);
            q_wdata <= cpu_wdata;
            q_big   <= big_endian;
         end
         if (tr_req && tr_ack) begin
            base <= tr_paddr & ~32'((1 << OFF_W) - 1);
            beat <= '0;
         end else if (beat_go && (state == ST_WB || state == ST_FILL)) begin
            beat <= beat + 1'b1;
         end
      end
   end

   always_comb begin
      state_nx      = state;
      cpu_done      = 1'b0;
      cpu_fault     = 1'b0;
      tr_req        = 1'b0;
      tr_write      = 1'b0;
      tr_vaddr      = q_addr;
      tr_pid        = q_pid;
      mem_valid     = 1'b0;
      mem_we        = 1'b0;
      mem_be        = 4'b1111;
      mem_addr      = base | (32'(beat) << 2);
      mem_wdata     = dat_rd;
      tag_wr_en     = 1'b0;
      tag_wr        = {q_addr[31:TAG_LO], PIDF_W'(q_pid), 1'b0};
      tag_set_dirty = 1'b0;
      dat_wr_en     = 1'b0;
      dat_be        = lane_be;
      dat_wr        = lane_wrep;
      sel_mem       = 1'b0;
      dat_addr      = q_addr[TAG_LO-1:2];
      unique case (state)
         ST_IDLE: begin
            if (cpu_req) state_nx = (cpu_addr[31:28] == UNC_NIB) ? ST_UNC : ST_CHECK;
         end
         ST_CHECK: begin
            if (hit) begin
               cpu_done = 1'b1;
               if (q_we) begin
                  dat_wr_en     = 1'b1;
                  tag_set_dirty = 1'b1;
               end
               state_nx = ST_IDLE;
            end else if (tag_dirty) begin
               state_nx = ST_TR_WB;
            end else begin
               state_nx = ST_TR_FILL;
            end
         end
         ST_TR_WB: begin
            tr_req   = 1'b1;
            tr_write = 1'b1;
            tr_vaddr = {tag_addr, q_addr[TAG_LO-1:OFF_W], OFF_W'(0)};
            tr_pid   = tag_pidf[PID_W-1:0];
            if (tr_ack) begin
               if (tr_fault) begin
                  cpu_done  = 1'b1;
                  cpu_fault = 1'b1;
                  state_nx  = ST_IDLE;
               end else begin
                  state_nx = ST_WB;
               end
            end
         end
         ST_WB: begin
            mem_valid = 1'b1;
            mem_we    = 1'b1;
            dat_addr  = {q_addr[TAG_LO-1:OFF_W], beat};
            if (beat_go && beat == LAST_BEAT) state_nx = ST_TR_FILL;
         end
         ST_TR_FILL: begin
            tr_req   = 1'b1;
            tr_write = q_we;
            if (tr_ack) begin
               if (tr_fault) begin
                  cpu_done  = 1'b1;
                  cpu_fault = 1'b1;
                  state_nx  = ST_IDLE;
               end else begin
                  state_nx = ST_FILL;
               end
            end
         end
         ST_FILL: begin
            mem_valid = 1'b1;
            dat_addr  = {q_addr[TAG_LO-1:OFF_W], beat};
            dat_be    = 4'b1111;
            dat_wr    = mem_rdata;
            if (beat_go) begin
               dat_wr_en = 1'b1;
               if (beat == LAST_BEAT) begin
                  tag_wr_en = 1'b1;
                  state_nx  = ST_CHECK;
               end
            end
         end
         ST_UNC: begin
            mem_valid = 1'b1;
            mem_we    = q_we;
            mem_be    = lane_be;
            mem_addr  = q_addr;
            mem_wdata = lane_wrep;
            sel_mem   = 1'b1;
            if (beat_go) begin
               cpu_done = 1'b1;
               state_nx = ST_IDLE;
            end
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   assign tag_idx  = q_addr[TAG_LO-1:OFF_W];
   assign cpu_busy = (state != ST_IDLE);

   // R11: an unaccepted memory beat keeps its request unchanged
   a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

   // R11: busy does not drop before completion
   a_r11_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_busy && !cpu_done) |=> cpu_busy);

   // R10: a translation fault is followed by no memory or translation activity
   a_r10_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (tr_req && tr_ack && tr_fault) |=> (!mem_valid && !tr_req));

   // R4: line beats advance by one word
   a_r4_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_FILL || state == ST_WB) && beat_go && beat != LAST_BEAT)
         |=> (mem_addr == $past(mem_addr) + 32'd4));
endmodule

// File: rtl/vtc_cache.sv
module vtc_cache
   import vtc_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          CACHE_BYTES = 8192,
   parameter int          LINE_BYTES  = 32,
   parameter int          PID_W       = 8,
   parameter logic [31:0] TAG_RESET   = 32'hffff_0000,
   parameter logic [3:0]  UNC_NIB     = 4'h2,
   parameter logic [3:0]  SHARE_NIB   = 4'h1,
   localparam int         LANES       = DATA_W / 8,
   localparam int         LINE_WORDS  = LINE_BYTES / LANES,
   localparam int         NUM_LINES   = CACHE_BYTES / LINE_BYTES,
   localparam int         OFF_W       = $clog2(LINE_BYTES),
   localparam int         IDX_W       = $clog2(NUM_LINES),
   localparam int         WOFF_W      = $clog2(LINE_WORDS),
   localparam int         DAW         = IDX_W + WOFF_W,
   localparam int         NUM_WORDS   = NUM_LINES * LINE_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_endian,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_size,
   input  logic [31:0]       cpu_addr,
   input  logic [31:0]       cpu_wdata,
   input  logic [PID_W-1:0]  cpu_pid,
   output logic              cpu_busy,
   output logic              cpu_done,
   output logic              cpu_fault,
   output logic [31:0]       cpu_rdata,
   output logic              tr_req,
   output logic              tr_write,
   output logic [31:0]       tr_vaddr,
   output logic [PID_W-1:0]  tr_pid,
   input  logic              tr_ack,
   input  logic              tr_fault,
   input  logic [31:0]       tr_paddr,
   output logic              mem_valid,
   output logic              mem_we,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ready,
   input  logic [31:0]       mem_rdata
);
   if (DATA_W != 32) begin : g_bad_width
      $error("vtc_cache: DATA_W must be 32");
   end
   if ((1 << OFF_W) != LINE_BYTES || (1 << IDX_W) != NUM_LINES) begin : g_bad_geom
      $error("vtc_cache: line size and line count must be powers of two");
   end
   if (PID_W > OFF_W + IDX_W - 1) begin : g_bad_pid
      $error("vtc_cache: process ID does not fit below the address tag");
   end

   logic [IDX_W-1:0] tag_idx;
   logic [31:0]      tag_rd, tag_wr;
   logic             tag_wr_en, tag_set_dirty;
   logic [DAW-1:0]   dat_addr;
   logic [31:0]      dat_rd, dat_wr;
   logic             dat_wr_en;
   logic [3:0]       dat_be;
   logic             q_big, q_we, sel_mem;
   vtc_size_e        q_size;
   logic [1:0]       q_addr_lo;
   logic [31:0]      q_wdata, lane_wrep, lane_word;
   logic [3:0]       lane_be;

   vtc_ctrl #(
      .PID_W(PID_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .WOFF_W(WOFF_W),
      .UNC_NIB(UNC_NIB), .SHARE_NIB(SHARE_NIB)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_pid(cpu_pid),
      .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_fault(cpu_fault),
      .tr_req(tr_req), .tr_write(tr_write), .tr_vaddr(tr_vaddr), .tr_pid(tr_pid),
      .tr_ack(tr_ack), .tr_fault(tr_fault), .tr_paddr(tr_paddr),
      .mem_valid(mem_valid), .mem_we(mem_we), .mem_be(mem_be),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .tag_idx(tag_idx), .tag_rd(tag_rd), .tag_wr_en(tag_wr_en),
      .tag_wr(tag_wr), .tag_set_dirty(tag_set_dirty),
      .dat_addr(dat_addr), .dat_rd(dat_rd), .dat_wr_en(dat_wr_en),
      .dat_be(dat_be), .dat_wr(dat_wr),
      .q_big(q_big), .q_size(q_size), .q_addr_lo(q_addr_lo),
      .q_wdata(q_wdata), .q_we(q_we), .sel_mem(sel_mem),
      .lane_be(lane_be), .lane_wrep(lane_wrep)
   );

   vtc_tag_store #(
      .LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(32), .RESET_VAL(TAG_RESET)
   ) i_tags (
      .clk(clk), .rst_n(rst_n), .idx_i(tag_idx), .tag_o(tag_rd),
      .wr_en_i(tag_wr_en), .wr_tag_i(tag_wr), .set_dirty_i(tag_set_dirty)
   );

   vtc_data_store #(
      .WORDS(NUM_WORDS), .AW(DAW), .LANES(LANES)
   ) i_data (
      .clk(clk), .addr_i(dat_addr), .rd_o(dat_rd),
      .wr_en_i(dat_wr_en), .be_i(dat_be), .wr_i(dat_wr)
   );

   assign lane_word = sel_mem ? mem_rdata : dat_rd;

   vtc_lane i_lane (
      .big_i(q_big), .size_i(q_size), .addr_lo_i(q_addr_lo),
      .wdata_i(q_wdata), .word_i(lane_word),
      .rdata_o(cpu_rdata), .wrep_o(lane_wrep), .be_o(lane_be)
   );

   // R9: narrow loads are zero-extended
   a_r9_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && !cpu_fault && !q_we && q_size == SZ_BYTE) |-> (cpu_rdata[31:8] == 24'd0));
   a_r9_half_zext: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && !cpu_fault && !q_we && q_size == SZ_HALF) |-> (cpu_rdata[31:16] == 16'd0));
endmodule

// File: tb/test_vtc_cache.sv
module test_vtc_cache;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] XLATE_OFS = 32'h0010_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic big_endian = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0;
   logic [1:0] cpu_size = 2'd2;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [7:0] cpu_pid = '0;
   logic cpu_busy, cpu_done, cpu_fault;
   logic [31:0] cpu_rdata;
   logic tr_req, tr_write, tr_ack, tr_fault;
   logic [31:0] tr_vaddr, tr_paddr;
   logic [7:0] tr_pid;
   logic mem_valid, mem_we, mem_ready;
   logic [3:0] mem_be;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   int n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vtc_cache i_vtc_cache (.*);

   // translation model: fixed offset, region 0x7 faults, answers at once
   assign tr_ack   = tr_req;
   assign tr_paddr = tr_vaddr + XLATE_OFS;
   assign tr_fault = (tr_vaddr[31:28] == 4'h7);

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[31:2], 2'b00} ^ 32'ha5c3_0f1e;
   endfunction

   logic [31:0] mem_q [logic [31:0]];
   logic rdy_q = 1'b0;
   assign mem_ready = rdy_q;
   assign mem_rdata = mem_q.exists({mem_addr[31:2], 2'b00}) ? mem_q[{mem_addr[31:2], 2'b00}]
                                                            : pat(mem_addr);

   int rd_n = 0, wr_n = 0, tr_n = 0;
   logic [31:0] rlog [256];
   logic [31:0] wlog [256];
   logic [31:0] wdlog [256];
   logic [3:0]  belog [256];
   logic [31:0] tvlog [256];
   logic [7:0]  tplog [256];
   logic        twlog [256];

   always @(posedge clk) begin
      rdy_q <= ~rdy_q;
      if (mem_valid && mem_ready) begin
         if (mem_we) begin
            logic [31:0] w;
            w = mem_rdata;
            for (int b = 0; b < 4; b++) if (mem_be[b]) w[8*b +: 8] = mem_wdata[8*b +: 8];
            mem_q[{mem_addr[31:2], 2'b00}] = w;
            wlog[wr_n & 255] = mem_addr;
            wdlog[wr_n & 255] = mem_wdata;
            belog[wr_n & 255] = mem_be;
            wr_n++;
         end else begin
            rlog[rd_n & 255] = mem_addr;
            rd_n++;
         end
      end
      if (tr_req && tr_ack) begin
         tvlog[tr_n & 255] = tr_vaddr;
         tplog[tr_n & 255] = tr_pid;
         twlog[tr_n & 255] = tr_write;
         tr_n++;
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   int s_rd, s_wr, s_tr, d_rd, d_wr, d_tr, gaps;
   logic [31:0] r_data;
   logic r_flt;

   task automatic acc(input logic we, input logic [1:0] sz, input logic [31:0] a,
                      input logic [31:0] wd, input logic [7:0] pid, input logic be);
      int guard = 0;
      s_rd = rd_n; s_wr = wr_n; s_tr = tr_n; gaps = 0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a;
      cpu_wdata = wd; cpu_pid = pid; big_endian = be;
      forever begin
         @(negedge clk);
         guard++;
         if (cpu_done) begin
            r_data = cpu_rdata;
            r_flt = cpu_fault;
            break;
         end
         if (!cpu_busy) gaps++;
         if (guard > 400) begin
            chk("R11 access completes", 32'd0, 32'd1);
            break;
         end
      end
      cpu_req = 1'b0;
      @(negedge clk);
      d_rd = rd_n - s_rd; d_wr = wr_n - s_wr; d_tr = tr_n - s_tr;
   endtask

   task automatic t_reset;
      chk("R11 reset busy", 32'(cpu_busy), 0);
      chk("R11 reset mem_valid", 32'(mem_valid), 0);
      chk("R11 reset tr_req", 32'(tr_req), 0);
   endtask

   task automatic t_reset_tags;
      acc(0, 2, 32'hffff_0040, 0, 8'd0, 0);
      chk("R1 reset tag hit: no reads", d_rd, 0);
      chk("R1 reset tag hit: no translation", d_tr, 0);
   endtask

   task automatic t_clean_miss;
      acc(0, 2, 32'h1000_0084, 0, 8'd1, 0);
      chk("R4 read beats", d_rd, 8);
      chk("R4 write beats", d_wr, 0);
      chk("R4 translations", d_tr, 1);
      chk("R4 translate pid", 32'(tplog[s_tr & 255]), 32'd1);
      chk("R4 translate write flag", 32'(twlog[s_tr & 255]), 0);
      chk("R4 translate vaddr", tvlog[s_tr & 255], 32'h1000_0084);
      chk("R4 first beat", rlog[s_rd & 255], 32'h1010_0080);
      chk("R4 last beat", rlog[(s_rd + 7) & 255], 32'h1010_009c);
      chk("R4 data", r_data, pat(32'h1010_0084));
      chk("R11 busy held", gaps, 0);
   endtask

   task automatic t_hit;
      acc(0, 2, 32'h1000_0088, 0, 8'd1, 0);
      chk("R3 hit beats", d_rd + d_wr, 0);
      chk("R3 hit translations", d_tr, 0);
      chk("R3 hit data", r_data, pat(32'h1010_0088));
   endtask

   task automatic t_narrow_loads;
      logic [31:0] p;
      p = pat(32'h1010_0084);
      acc(0, 0, 32'h1000_0085, 0, 8'd1, 0);
      chk("R9 byte le", r_data, (p >> 8) & 32'hff);
      acc(0, 1, 32'h1000_0086, 0, 8'd1, 0);
      chk("R9 half le", r_data, (p >> 16) & 32'hffff);
      acc(0, 0, 32'h1000_0085, 0, 8'd1, 1);
      chk("R9 byte be", r_data, (p >> 16) & 32'hff);
      acc(0, 1, 32'h1000_0084, 0, 8'd1, 1);
      chk("R9 half be", r_data, (p >> 16) & 32'hffff);
   endtask

   logic [31:0] exp88, exp8c;

   task automatic t_narrow_stores;
      exp88 = (pat(32'h1010_0088) & 32'hffff_00ff) | 32'h0000_5a00;
      exp8c = (pat(32'h1010_008c) & 32'h0000_ffff) | 32'h1234_0000;
      acc(1, 0, 32'h1000_0089, 32'h0000_005a, 8'd1, 0);
      chk("R8 byte store no traffic", d_rd + d_wr, 0);
      acc(0, 2, 32'h1000_0088, 0, 8'd1, 0);
      chk("R8 byte merge le", r_data, exp88);
      acc(1, 1, 32'h1000_008c, 32'h0000_1234, 8'd1, 1);
      acc(0, 2, 32'h1000_008c, 0, 8'd1, 0);
      chk("R8 half merge be", r_data, exp8c);
   endtask

   task automatic t_pid_and_writeback;
      acc(0, 2, 32'h1000_0084, 0, 8'd2, 0);
      chk("R6 shared-region read hits", d_rd, 0);
      acc(1, 2, 32'h1000_0090, 32'hdead_beef, 8'd2, 0);
      chk("R5 writeback beats", d_wr, 8);
      chk("R5 refill beats", d_rd, 8);
      chk("R5 victim vaddr", tvlog[s_tr & 255], 32'h1000_0080);
      chk("R5 victim pid", 32'(tplog[s_tr & 255]), 32'd1);
      chk("R5 victim write flag", 32'(twlog[s_tr & 255]), 1);
      chk("R5 first writeback addr", wlog[s_wr & 255], 32'h1010_0080);
      chk("R7 dirty word written back", mem_q[32'h1010_0088], exp88);
      chk("R7 dirty half written back", mem_q[32'h1010_008c], exp8c);
      chk("R6 refill pid", 32'(tplog[(s_tr + 1) & 255]), 32'd2);
      acc(0, 2, 32'h1000_0090, 0, 8'd2, 0);
      chk("R7 store after refill", r_data, 32'hdead_beef);
   endtask

   task automatic t_pid_private;
      acc(0, 2, 32'h0400_0100, 0, 8'd3, 0);
      chk("R4 private fill", d_rd, 8);
      acc(0, 2, 32'h0400_0100, 0, 8'd4, 0);
      chk("R6 pid mismatch misses", d_rd, 8);
      chk("R6 pid mismatch data", r_data, pat(32'h0410_0100));
   endtask

   task automatic t_faults;
      acc(0, 2, 32'h7000_0200, 0, 8'd1, 0);
      chk("R10 read fault flag", 32'(r_flt), 1);
      chk("R10 read fault beats", d_rd + d_wr, 0);
      acc(1, 2, 32'h7000_0090, 32'h1111_1111, 8'd2, 0);
      chk("R10 fault flag after writeback", 32'(r_flt), 1);
      chk("R10 writeback kept", d_wr, 8);
      chk("R10 no refill", d_rd, 0);
      chk("R5 writeback data", mem_q[32'h1010_0090], 32'hdead_beef);
      acc(0, 2, 32'h1000_0090, 0, 8'd2, 0);
      chk("R10 line untouched: hit", d_rd, 0);
      chk("R10 line untouched: data", r_data, 32'hdead_beef);
   endtask

   task automatic t_uncached;
      acc(1, 0, 32'h2000_0013, 32'h0000_00c3, 8'd1, 0);
      chk("R2 one beat", d_wr + d_rd, 1);
      chk("R2 no translation", d_tr, 0);
      chk("R2 raw address", wlog[s_wr & 255], 32'h2000_0013);
      chk("R2 byte enables", 32'(belog[s_wr & 255]), 32'h8);
      chk("R2 replicated data", wdlog[s_wr & 255], 32'hc3c3_c3c3);
      acc(0, 2, 32'h2000_0010, 0, 8'd1, 0);
      chk("R2 read back", r_data, (pat(32'h2000_0010) & 32'h00ff_ffff) | 32'hc300_0000);
      chk("R2 read raw address", rlog[s_rd & 255], 32'h2000_0010);
      acc(0, 2, 32'h1000_0090, 0, 8'd2, 0);
      chk("R2 cache unchanged", r_data, 32'hdead_beef);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reset_tags();
      t_clean_miss();
      t_hit();
      t_narrow_loads();
      t_narrow_stores();
      t_pid_and_writeback();
      t_pid_private();
      t_faults();
      t_uncached();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule